// File: doc/BRIEF.md
# Bus Master Burst Transaction Sequencer

This block is the initiator-side sequencer for a 32-bit multiplexed address/data bus. A local processor loads a control register with the upper address half, a burst length, a read-lane format code, a count-enable bit, a bus-master mode bit and a master-terminate bit. When the processor writes the lower address half in bus-master mode, the burst counter is preset and the block asks for bus ownership. After the arbiter grants the bus, the block drives the full 32-bit address for one cycle. It then runs data phases until the burst ends.

A burst ends on one of four conditions: the down-counter, preset to the number of accesses minus one, reaches zero and one further data phase completes; the target signals stop; the grant is withdrawn; or software sets the terminate bit. The counter value left at the end is stored in a status field, and a one-cycle done pulse is raised. Each completed data phase places three of the four bus bytes into a 24-bit receive register. The format code chooses which three bytes.

Top module: `burst_master_seq`

## Requirements
- R1: After synchronous reset, `bus_req`, `ad_oe`, `frame`, `irdy`, `rx_valid`, `done`, `overrun`, `abort_pend` and `busy` are 0, `ad_out` is 0 and `remain_cnt` is 0.
- R2: Control word layout: bits [15:0] upper address, [21:16] burst length, [23:22] format, [24] count enable, [25] bus-master mode, [26] terminate. A write on `addr_wr` while idle with mode bit 1 raises `bus_req` and `busy` from the next cycle. With mode bit 0 the write is ignored.
- R3: `bus_req` stays high until `bus_gnt` is sampled high. The following cycle is the address phase, which lasts exactly one cycle: `ad_oe` and `frame` are high and `ad_out` equals {upper half, lower half}.
- R4: Data phases follow the address phase with `frame` and `irdy` high. A phase transfers data only in a cycle where `trdy` is high. With count enable set, each transfer with a nonzero counter decrements the counter by 1.
- R5: With count enable set and no early end, a burst length field of N gives exactly N+1 transfers (0 gives 1, 63 gives 64).
- R6: `stop` sampled high in a data phase ends the burst after that cycle. A transfer in the same cycle still counts.
- R7: `bus_gnt` sampled low in the address or a data phase ends the burst after that cycle.
- R8: A control write with bit 26 set while busy raises `abort_pend` from the next cycle, and the burst ends one cycle later. `abort_pend` reads 0 from the cycle after the sequencer is idle, and a terminate write made while idle has no effect.
- R9: After the last phase there is one turnaround cycle. `remain_cnt` then takes the counter value, and `done` is high for exactly one cycle together with the update.
- R10: On each transfer, `rx_valid` pulses the next cycle and `rx_data` takes `ad_in[31:8]` for format code 3, or `ad_in[23:0]` for any other code. The format is the one held when the burst started.
- R11: An `addr_wr` while busy is ignored: the running address is unchanged and `overrun` is set. `overrun` stays set until the next accepted start clears it.
- R12: With count enable clear, the counter holds its preset value. The burst runs until stop, grant loss or terminate, and `remain_cnt` reports the preset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 27 | Control word |
| addr_wr | input | 1 | Lower address write strobe, starts a burst |
| addr_wdata | input | 16 | Lower address half |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| ad_out | output | 32 | Address driven in the address phase |
| ad_oe | output | 1 | Address drive enable |
| ad_in | input | 32 | Read data from the bus |
| frame | output | 1 | Transaction active (address and data phases) |
| irdy | output | 1 | Initiator ready (data phases) |
| trdy | input | 1 | Target ready |
| stop | input | 1 | Target termination request |
| rx_data | output | 24 | Receive register |
| rx_valid | output | 1 | One-cycle pulse after each transfer |
| remain_cnt | output | 6 | Counter value at the end of the last burst |
| done | output | 1 | One-cycle burst completion pulse |
| overrun | output | 1 | Start write seen while busy |
| abort_pend | output | 1 | Terminate request pending |
| busy | output | 1 | Sequencer not idle |

## Verification
On every cycle, the assertions check that the address phase lasts a single cycle and follows a sampled grant. They also check that stop or grant loss during a data phase drops the data phase on the next cycle, that each receive pulse comes after a ready handshake, and that done is a single-cycle pulse. Further checks cover the remaining-count field changing only with done, the terminate bit clearing once idle, and a busy start write setting overrun. The exact number of transfers per burst length, the leftover count after each early-end cause, the lane selection per format code, the ignored non-master start and the effect of a cleared count enable are shown only by the bench scenarios, which compare against a cycle model.

// File: rtl/bms_pkg.sv
package bms_pkg;

    localparam int HALF_W  = 16;
    localparam int BUS_W   = 2 * HALF_W;
    localparam int BLEN_W  = 6;
    localparam int FMT_W   = 2;
    localparam int RX_W    = 24;
    localparam int BLEN_LO = HALF_W;
    localparam int FMT_LO  = BLEN_LO + BLEN_W;
    localparam int CEN_BIT = FMT_LO + FMT_W;
    localparam int MM_BIT  = CEN_BIT + 1;
    localparam int ABT_BIT = MM_BIT + 1;
    localparam int CFG_W   = ABT_BIT + 1;
    localparam logic [FMT_W-1:0] FMT_UPPER = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_TURN
    } seq_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [BLEN_W-1:0] blen;
        logic [FMT_W-1:0]  fmt;
        logic              cen;
        logic              mm;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [CFG_W-1:0] w);
        ctrl_t c;
        c.hi   = w[HALF_W-1:0];
        c.blen = w[BLEN_LO +: BLEN_W];
        c.fmt  = w[FMT_LO +: FMT_W];
        c.cen  = w[CEN_BIT];
        c.mm   = w[MM_BIT];
        return c;
    endfunction

    function automatic logic [RX_W-1:0] lane_pick(input logic [FMT_W-1:0] fmt,
                                                  input logic [BUS_W-1:0] w);
        return (fmt == FMT_UPPER) ? w[BUS_W-1 -: RX_W] : w[RX_W-1:0];
    endfunction

endpackage

// File: rtl/bms_ctrl_reg.sv
module bms_ctrl_reg
    import bms_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             seq_idle,
    output ctrl_t            ctrl,
    output logic             abort
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            abort <= 1'b0;
        end else begin
            if (cfg_wr) begin
                ctrl <= unpack_ctrl(cfg_wdata);
            end
            if (seq_idle) begin
                abort <= 1'b0;
            end else if (cfg_wr && cfg_wdata[ABT_BIT]) begin
                abort <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bms_rx_lane.sv
module bms_rx_lane
    import bms_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer,
    input  logic [FMT_W-1:0] fmt,
    input  logic [BUS_W-1:0] ad_in,
    output logic [RX_W-1:0]  rx_data,
    output logic             rx_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= xfer;
            if (xfer) begin
                rx_data <= lane_pick(fmt, ad_in);
            end
        end
    end

endmodule

// File: rtl/bms_fsm.sv
module bms_fsm
    import bms_pkg::*;
#(
    parameter int CNT_W = BLEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_wr,
    input  logic [HALF_W-1:0] addr_lo,
    input  ctrl_t             ctrl,
    input  logic              abort,
    input  logic              gnt,
    input  logic              trdy,
    input  logic              stop,
    output seq_state_e        state,
    output logic [BUS_W-1:0]  addr,
    output logic [FMT_W-1:0]  fmt_l,
    output logic              xfer,
    output logic [CNT_W-1:0]  remain,
    output logic              done,
    output logic              overrun
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt;
    logic             cen_l;
    logic             cnt_end;
    logic             data_end;

    assign xfer     = (state == ST_DATA) && trdy;
    assign cnt_end  = cen_l && xfer && (cnt == CNT_ZERO);
    assign data_end = abort || !gnt || stop || cnt_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            cen_l   <= 1'b0;
            addr    <= '0;
            fmt_l   <= '0;
            remain  <= '0;
            done    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            done <= (state == ST_TURN);
            if (addr_wr && (state != ST_IDLE)) begin
                overrun <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (addr_wr && ctrl.mm) begin
                        state   <= ST_REQ;
                        cnt     <= CNT_W'(ctrl.blen);
                        cen_l   <= ctrl.cen;
                        addr    <= {ctrl.hi, addr_lo};
                        fmt_l   <= ctrl.fmt;
                        overrun <= 1'b0;
                    end
                end
                ST_REQ: begin
                    if (abort) begin
                        state <= ST_TURN;
                    end else if (gnt) begin
                        state <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    state <= (abort || !gnt) ? ST_TURN : ST_DATA;
                end
                ST_DATA: begin
                    if (xfer && cen_l && (cnt != CNT_ZERO)) begin
                        cnt <= cnt - 1'b1;
                    end
                    if (data_end) begin
                        state <= ST_TURN;
                    end
                end
                ST_TURN: begin
                    remain <= cnt;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/burst_master_seq.sv
module burst_master_seq
    import bms_pkg::*;
#(
    parameter int CNT_W = BLEN_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                addr_wr,
    input  logic [HALF_W-1:0]   addr_wdata,
    output logic                bus_req,
    input  logic                bus_gnt,
    output logic [BUS_W-1:0]    ad_out,
    output logic                ad_oe,
    input  logic [BUS_W-1:0]    ad_in,
    output logic                frame,
    output logic                irdy,
    input  logic                trdy,
    input  logic                stop,
    output logic [RX_W-1:0]     rx_data,
    output logic                rx_valid,
    output logic [CNT_W-1:0]    remain_cnt,
    output logic                done,
    output logic                overrun,
    output logic                abort_pend,
    output logic                busy
);

    ctrl_t            ctrl;
    seq_state_e       state;
    logic [BUS_W-1:0] addr;
    logic [FMT_W-1:0] fmt_l;
    logic             xfer;

    bms_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .seq_idle  (state == ST_IDLE),
        .ctrl      (ctrl),
        .abort     (abort_pend)
    );

    bms_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .addr_wr (addr_wr),
        .addr_lo (addr_wdata),
        .ctrl    (ctrl),
        .abort   (abort_pend),
        .gnt     (bus_gnt),
        .trdy    (trdy),
        .stop    (stop),
        .state   (state),
        .addr    (addr),
        .fmt_l   (fmt_l),
        .xfer    (xfer),
        .remain  (remain_cnt),
        .done    (done),
        .overrun (overrun)
    );

    bms_rx_lane u_rx (
        .clk      (clk),
        .rst      (rst),
        .xfer     (xfer),
        .fmt      (fmt_l),
        .ad_in    (ad_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    assign bus_req = (state == ST_REQ);
    assign ad_oe   = (state == ST_ADDR);
    assign ad_out  = ad_oe ? addr : '0;
    assign frame   = (state == ST_ADDR) || (state == ST_DATA);
    assign irdy    = (state == ST_DATA);
    assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/bms_checker.sv
module bms_checker #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             ad_oe,
    input logic             frame,
    input logic             irdy,
    input logic             trdy,
    input logic             stop,
    input logic             rx_valid,
    input logic             done,
    input logic [CNT_W-1:0] remain_cnt,
    input logic             abort_pend,
    input logic             busy,
    input logic             addr_wr,
    input logic             overrun
);

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !abort_pend) |=> bus_req); // R3
    AST_ADDR_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> ($past(bus_req) && $past(bus_gnt))); // R3
    AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ad_oe |=> !ad_oe); // R3
    AST_RX_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(irdy && trdy)); // R4
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (irdy && stop) |=> !frame); // R6
    AST_GNT_LOSS_ENDS: assert property (@(posedge clk) disable iff (rst)
        (frame && !bus_gnt) |=> !frame); // R7
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(!busy) |-> !abort_pend); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_REMAIN_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(remain_cnt) |-> done); // R9
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (busy && addr_wr) |=> overrun); // R11

endmodule

bind burst_master_seq bms_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/burst_master_seq_tb.sv
module burst_master_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [26:0] cfg_wdata = '0;
    logic        addr_wr = 1'b0;
    logic [15:0] addr_wdata = '0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic [31:0] ad_in = '0;
    logic        frame;
    logic        irdy;
    logic        trdy = 1'b0;
    logic        stop = 1'b0;
    logic [23:0] rx_data;
    logic        rx_valid;
    logic [5:0]  remain_cnt;
    logic        done;
    logic        overrun;
    logic        abort_pend;
    logic        busy;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    burst_master_seq dut_i (.*);

    always #10 clk = ~clk;

    // ---------------- reference model ----------------
    int          m_ph;          // 0 idle 1 req 2 addr 3 data 4 turn
    int          m_left;
    logic [15:0] m_hi;
    int          m_blen;
    int          m_fmt, m_fmt_l;
    bit          m_cen, m_cen_l, m_mm, m_abort;
    logic [31:0] m_addr;
    logic [23:0] m_rx;
    bit          m_rxv, m_done, m_ovr;
    int          m_rem;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_left = 0; m_hi = '0; m_blen = 0; m_fmt = 0; m_fmt_l = 0;
            m_cen = 0; m_cen_l = 0; m_mm = 0; m_abort = 0; m_addr = '0;
            m_rx = '0; m_rxv = 0; m_done = 0; m_ovr = 0; m_rem = 0;
        end else begin
            int nph = m_ph;
            int nleft = m_left;
            bit nabort;
            bit x;
            m_done = (m_ph == 4);
            m_rxv = 0;
            if (addr_wr && m_ph != 0) m_ovr = 1;
            nabort = (m_ph == 0) ? 1'b0 : ((cfg_wr && cfg_wdata[26]) ? 1'b1 : m_abort);
            case (m_ph)
                0: if (addr_wr && m_mm) begin
                    nph = 1; nleft = m_blen; m_addr = {m_hi, addr_wdata};
                    m_fmt_l = m_fmt; m_cen_l = m_cen; m_ovr = 0;
                end
                1: if (m_abort) nph = 4; else if (bus_gnt) nph = 2;
                2: nph = (m_abort || !bus_gnt) ? 4 : 3;
                3: begin
                    x = trdy;
                    if (x) begin
                        m_rxv = 1;
                        m_rx = (m_fmt_l == 3) ? ad_in[31:8] : ad_in[23:0];
                        if (m_cen_l && m_left != 0) nleft = m_left - 1;
                    end
                    if (m_abort || !bus_gnt || stop || (m_cen_l && x && m_left == 0)) nph = 4;
                end
                default: begin m_rem = m_left; nph = 0; end
            endcase
            if (cfg_wr) begin
                m_hi = cfg_wdata[15:0]; m_blen = int'(cfg_wdata[21:16]);
                m_fmt = int'(cfg_wdata[23:22]); m_cen = cfg_wdata[24]; m_mm = cfg_wdata[25];
            end
            m_abort = nabort;
            m_ph = nph;
            m_left = nleft;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2", "model bus_req", 32'(bus_req), 32'(m_ph == 1));
            chk("R2", "model busy", 32'(busy), 32'(m_ph != 0));
            chk("R3", "model ad_oe", 32'(ad_oe), 32'(m_ph == 2));
            chk("R3", "model ad_out", ad_out, (m_ph == 2) ? m_addr : 32'h0);
            chk("R4", "model frame", 32'(frame), 32'(m_ph == 2 || m_ph == 3));
            chk("R4", "model irdy", 32'(irdy), 32'(m_ph == 3));
            chk("R10", "model rx_valid", 32'(rx_valid), 32'(m_rxv));
            chk("R10", "model rx_data", 32'(rx_data), 32'(m_rx));
            chk("R9", "model remain_cnt", 32'(remain_cnt), 32'(m_rem));
            chk("R9", "model done", 32'(done), 32'(m_done));
            chk("R11", "model overrun", 32'(overrun), 32'(m_ovr));
            chk("R8", "model abort_pend", 32'(abort_pend), 32'(m_abort));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [26:0] cfg_word(input int hi, input int blen, input int fmt,
                                             input bit cen, input bit mm, input bit abt);
        return {abt, mm, cen, fmt[1:0], blen[5:0], hi[15:0]};
    endfunction

    task automatic run_burst(input string tag, input int blen, input int fmt, input bit cen,
                             input bit alt, input int stop_at, input int drop_at,
                             input int abort_at, input int gnt_delay, input bit extra_wr,
                             input int exp_beats, input int exp_rem);
        int hi = 16'h4000 + blen * 3;
        int lo = 16'h0100 + blen;
        int beats = 0;
        int rxn = 0;
        int cyc = 0;
        bit aborting = 0;
        logic [31:0] last_word = '0;
        cfg_wr = 1; cfg_wdata = cfg_word(hi, blen, fmt, cen, 1, 0);
        @(negedge clk);
        cfg_wr = 0; addr_wr = 1; addr_wdata = 16'(lo);
        @(negedge clk);
        addr_wr = 0;
        chk("R2", {tag, " request after start"}, 32'(bus_req), 32'h1);
        chk("R11", {tag, " overrun cleared on start"}, 32'(overrun), 32'(extra_wr ? 0 : overrun));
        for (int d = 0; d < gnt_delay; d++) begin
            if (extra_wr && d == 0) begin addr_wr = 1; addr_wdata = 16'hFFFF; end
            @(negedge clk);
            addr_wr = 0;
            chk("R3", {tag, " request held without grant"}, 32'(bus_req), 32'h1);
            chk("R3", {tag, " no address before grant"}, 32'(ad_oe), 32'h0);
        end
        if (extra_wr) chk("R11", {tag, " overrun set"}, 32'(overrun), 32'h1);
        bus_gnt = 1;
        @(negedge clk);
        chk("R3", {tag, " address phase"}, ad_out, {hi[15:0], lo[15:0]});
        while (!done && cyc < 400) begin
            if (rx_valid) rxn++;
            trdy = 0; stop = 0;
            if (irdy) begin
                trdy = alt ? cyc[0] : 1'b1;
                if (abort_at >= 0 && beats == abort_at && !aborting) begin
                    cfg_wr = 1; cfg_wdata = cfg_word(hi, blen, fmt, cen, 1, 1);
                    aborting = 1;
                end
                if (aborting) trdy = 0;
                if (drop_at >= 0 && beats == drop_at) begin bus_gnt = 0; trdy = 0; end
                if (stop_at >= 0 && trdy && beats + 1 == stop_at) stop = 1;
                ad_in = {8'hA5, 8'(beats), 8'h3C, 8'(beats) + 8'h11};
                if (trdy) begin beats++; last_word = ad_in; end
            end
            @(negedge clk);
            if (cfg_wr) chk("R8", {tag, " terminate pending"}, 32'(abort_pend), 32'h1);
            cfg_wr = 0;
            cyc++;
        end
        trdy = 0; stop = 0; bus_gnt = 0;
        chk("R9", {tag, " done seen"}, 32'(done), 32'h1);
        chk("R5", {tag, " transfer count"}, 32'(rxn), 32'(exp_beats));
        chk("R9", {tag, " remaining count"}, 32'(remain_cnt), 32'(exp_rem));
        if (exp_beats > 0)
            chk("R10", {tag, " lane select"}, 32'(rx_data),
                32'((fmt == 3) ? last_word[31:8] : last_word[23:0]));
        @(negedge clk);
        chk("R9", {tag, " done single pulse"}, 32'(done), 32'h0);
        chk("R8", {tag, " terminate cleared when idle"}, 32'(abort_pend), 32'h0);
        chk("R2", {tag, " idle after burst"}, 32'(busy), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset bus_req", 32'(bus_req), 32'h0);
        chk("R1", "reset busy", 32'(busy), 32'h0);
        chk("R1", "reset remain", 32'(remain_cnt), 32'h0);
        chk("R1", "reset flags", 32'({done, overrun, abort_pend, rx_valid, frame}), 32'h0);
        rst = 0;
        @(negedge clk);
        // R2: start ignored outside bus-master mode
        cfg_wr = 1; cfg_wdata = cfg_word(16'h1111, 3, 1, 1, 0, 0);
        @(negedge clk);
        cfg_wr = 0; addr_wr = 1; addr_wdata = 16'h2222;
        @(negedge clk);
        addr_wr = 0;
        chk("R2", "non-master start ignored req", 32'(bus_req), 32'h0);
        chk("R2", "non-master start ignored busy", 32'(busy), 32'h0);
        // R8: terminate write while idle has no effect
        cfg_wr = 1; cfg_wdata = cfg_word(16'h1111, 3, 1, 1, 1, 1);
        @(negedge clk);
        cfg_wr = 0;
        chk("R8", "idle terminate ignored", 32'(abort_pend), 32'h0);
        @(negedge clk);
        run_burst("R5 basic", 3, 1, 1, 0, -1, -1, -1, 0, 0, 4, 0);
        run_burst("R5 len0", 0, 2, 1, 0, -1, -1, -1, 1, 0, 1, 0);
        run_burst("R5 len63", 63, 1, 1, 0, -1, -1, -1, 0, 0, 64, 0);
        run_burst("R4 waits", 2, 0, 1, 1, -1, -1, -1, 2, 0, 3, 0);
        run_burst("R6 stop", 5, 1, 1, 0, 2, -1, -1, 0, 0, 2, 3);
        run_burst("R7 gnt loss", 7, 1, 1, 0, -1, 3, -1, 0, 0, 3, 4);
        run_burst("R8 terminate", 9, 1, 1, 0, -1, -1, 2, 0, 0, 2, 7);
        run_burst("R10 upper lanes", 1, 3, 1, 0, -1, -1, -1, 0, 0, 2, 0);
        run_burst("R11 busy start", 2, 3, 1, 0, -1, -1, -1, 3, 1, 3, 0);
        run_burst("R11 overrun clear", 1, 1, 1, 0, -1, -1, -1, 0, 0, 2, 0);
        run_burst("R12 no count", 4, 2, 0, 0, 6, -1, -1, 0, 0, 6, 4);
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule